// File: doc/BRIEF.md
# One-Time-Programmable Differential ROM

This block is a synthesizable behavioural model of a small write-once memory macro with 16 words of 8 bits. Each stored bit is a pair of complementary burn flags: a positive-side flag and a negative-side flag, both unburned when the part is new. Programming a bit burns exactly one flag of its pair. Reading a bit compares the two flags, so the value never depends on the absolute level of a single element.

The block also generates the array-side control that a real macro needs:
- an active-low, one-hot bank select decoded from the address;
- per-bit drive enables for the positive and negative sides;
- a discharge level;
- a precharge, then evaluate, read sequence whose compared result is latched into an output register.

Write data comes in on `data_in`. The read result leaves on `data_out` and its complement `data_out_n`. Both outputs are marked by `data_oe`, which models the shared data pins that the macro drives only while the result is valid. Once a word is programmed, it cannot be programmed again. A further write attempt leaves the word unchanged and is flagged.

Top module: `otp_diff_rom`

## Requirements
- R1: Each of the 16 addresses holds an 8-bit word. A word written once reads back exactly as written, including the all-zero and all-one words.
- R2: `bank_sel_n` always has exactly one bit low, at the index equal to `addr`. All other bits are high.
- R3: While `wr_en` is high and `rd_en` is low, `drv_pos` equals `data_in` and `drv_neg` equals its bitwise inverse.
- R4: While `rd_en` is high and `wr_en` is low, `drv_pos` and `drv_neg` are all ones and `discharge` is low.
- R5: When both strobes are equal (both high or both low), the block is idle:
  - both drive buses are zero;
  - `discharge` is high;
  - `precharge` and `evaluate` are low;
  - nothing is burned, so a word "written" with both strobes high still reads as blank.
- R6: While `rst` is high:
  - `precharge` and `evaluate` are low;
  - `discharge` is high;
  - both drive buses are zero.
  Any read in progress is abandoned, and the next read restarts its sequence from the beginning.
- R7: A read held from cycle 0 proceeds as follows:
  - `precharge` is high in cycles 0 to 2;
  - cycle 3 has neither `precharge` nor `evaluate`;
  - `evaluate` is high in cycle 4 only;
  - `data_oe` is high from cycle 5 for as long as the read is held.
- R8: A read result bit is 1 only when its positive-side flag is burned and its negative-side flag is not. Otherwise it is 0.
- R9: A write to a word that already has any flag burned leaves the stored word unchanged. It raises `reprog_err` for exactly one cycle: the cycle after the first write cycle.
- R10: Reading a word with no flag burned returns 0x00 with `blank` high. A programmed word reads with `blank` low.
- R11: Output enable behaviour:
  - `data_oe` is high only while a latched read result is valid. It drops in the cycle after `rd_en` falls.
  - While `data_oe` is low, `data_out` and `data_out_n` are zero. This covers the whole of a write.
  - While `data_oe` is high, `data_out_n` is the bitwise inverse of `data_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not erase burned flags) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| data_in | input | 8 | Data to program |
| data_out | output | 8 | Latched read result, zero when not valid |
| data_out_n | output | 8 | Complement of the read result, zero when not valid |
| data_oe | output | 1 | High while the read result is valid and the data pins are driven |
| bank_sel_n | output | 16 | Active-low one-hot bank select |
| drv_pos | output | 8 | Positive-side drive enables |
| drv_neg | output | 8 | Negative-side drive enables |
| precharge | output | 1 | Read precharge phase |
| evaluate | output | 1 | Read evaluate phase |
| discharge | output | 1 | Discharge level, low only during a read |
| reprog_err | output | 1 | One-cycle pulse on a write to an already programmed word |
| blank | output | 1 | The valid read result came from a never-programmed word |

## Verification
The properties assume that `addr` and `data_in` stay stable for the whole of a write or read strobe. They also assume that a write or read is entered from an idle cycle, so that the first-cycle burn detection and the counter restart line up with the strobe edge.

The stimulus follows these rules:
- inputs change only on falling clock edges;
- every write and read is framed by idle cycles, with address and data held throughout;
- both-strobes-high is applied only as a deliberate idle case;
- reset is applied once mid-read, to show the abandon-and-restart behaviour.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

    localparam int ADDR_W_DEF  = 4;
    localparam int DATA_W_DEF  = 8;
    localparam int PRE_CYC_DEF = 3;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef struct packed {
        logic precharge;
        logic evaluate;
        logic discharge;
        logic capture;
    } seq_ctl_t;

    // Conflicting or absent strobes both fall back to idle.
    function automatic op_e op_decode(input logic wr, input logic rd);
        if (wr && !rd) return OP_WRITE;
        if (rd && !wr) return OP_READ;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/otp_bank_decode.sv
module otp_bank_decode #(
    parameter int ADDR_W = otp_rom_pkg::ADDR_W_DEF,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  sel_n
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_bank
        assign sel_n[g] = (addr != ADDR_W'(g));
    end
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq
    import otp_rom_pkg::*;
#(
    parameter int PRE_CYC = PRE_CYC_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  op_e      op,
    output seq_ctl_t ctl
);
    localparam int EVAL_AT = PRE_CYC + 1;
    localparam int DONE_AT = PRE_CYC + 2;
    localparam int CNT_W   = $clog2(DONE_AT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             in_read;

    assign in_read = (op == OP_READ) && !rst;

    // Counter restarts whenever the read is not held; saturates at DONE_AT.
    always_ff @(posedge clk) begin
        if (rst || op != OP_READ)
            cnt_q <= '0;
        else if (cnt_q != CNT_W'(DONE_AT))
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        ctl.precharge = in_read && (cnt_q < CNT_W'(PRE_CYC));
        ctl.evaluate  = in_read && (cnt_q == CNT_W'(EVAL_AT));
        ctl.discharge = !in_read;
        ctl.capture   = ctl.evaluate;
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = otp_rom_pkg::ADDR_W_DEF,
    parameter int DATA_W = otp_rom_pkg::DATA_W_DEF,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              burn_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] flag_pos,
    output logic [DATA_W-1:0] flag_neg
);
    logic [DATA_W-1:0] pos_q [DEPTH];
    logic [DATA_W-1:0] neg_q [DEPTH];

    // Virgin part: every flag unburned; reset never touches the array.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            pos_q[i] = '0;
            neg_q[i] = '0;
        end
    end

    // Flags only ever move from unburned to burned.
    always @(posedge clk) begin
        if (burn_en) begin
            pos_q[addr] <= pos_q[addr] | wdata;
            neg_q[addr] <= neg_q[addr] | ~wdata;
        end
    end

    assign flag_pos = pos_q[addr];
    assign flag_neg = neg_q[addr];
endmodule

// File: rtl/otp_diff_rom.sv
module otp_diff_rom
    import otp_rom_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int PRE_CYC = PRE_CYC_DEF,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] data_out_n,
    output logic              data_oe,
    output logic [DEPTH-1:0]  bank_sel_n,
    output logic [DATA_W-1:0] drv_pos,
    output logic [DATA_W-1:0] drv_neg,
    output logic              precharge,
    output logic              evaluate,
    output logic              discharge,
    output logic              reprog_err,
    output logic              blank
);
    op_e               op;
    seq_ctl_t          ctl;
    logic [DATA_W-1:0] flag_pos, flag_neg, res_q;
    logic              prev_wr_q, err_q, valid_q, blank_q;
    logic              word_prog, wr_start, burn_en;

    assign op = op_decode(wr_en, rd_en);

    otp_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (addr),
        .sel_n (bank_sel_n)
    );

    otp_read_seq #(.PRE_CYC(PRE_CYC)) u_seq (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .ctl (ctl)
    );

    otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .burn_en  (burn_en),
        .addr     (addr),
        .wdata    (data_in),
        .flag_pos (flag_pos),
        .flag_neg (flag_neg)
    );

    assign word_prog = |(flag_pos | flag_neg);
    assign wr_start  = !rst && (op == OP_WRITE) && !prev_wr_q;
    assign burn_en   = wr_start && !word_prog;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_wr_q <= 1'b0;
            err_q     <= 1'b0;
            valid_q   <= 1'b0;
            blank_q   <= 1'b0;
            res_q     <= '0;
        end else begin
            prev_wr_q <= (op == OP_WRITE);
            err_q     <= wr_start && word_prog;
            if (op != OP_READ) begin
                valid_q <= 1'b0;
            end else if (ctl.capture) begin
                valid_q <= 1'b1;
                res_q   <= flag_pos & ~flag_neg;
                blank_q <= !word_prog;
            end
        end
    end

    always_comb begin
        drv_pos = '0;
        drv_neg = '0;
        if (!rst) begin
            case (op)
                OP_WRITE: begin drv_pos = data_in; drv_neg = ~data_in; end
                OP_READ:  begin drv_pos = '1;      drv_neg = '1;       end
                default:  ;
            endcase
        end
    end

    assign precharge  = ctl.precharge;
    assign evaluate   = ctl.evaluate;
    assign discharge  = ctl.discharge;
    assign reprog_err = err_q;
    assign data_oe    = valid_q;
    assign blank      = valid_q && blank_q;
    assign data_out   = valid_q ? res_q  : '0;
    assign data_out_n = valid_q ? ~res_q : '0;
endmodule

// File: rtl/otp_diff_rom_chk.sv
module otp_diff_rom_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] data_out,
    input logic [DATA_W-1:0] data_out_n,
    input logic              data_oe,
    input logic [DEPTH-1:0]  bank_sel_n,
    input logic [DATA_W-1:0] drv_pos,
    input logic [DATA_W-1:0] drv_neg,
    input logic              precharge,
    input logic              evaluate,
    input logic              discharge,
    input logic              reprog_err,
    input logic              blank
);
    p_onehot_sel_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(~bank_sel_n) == 1);

    p_write_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |-> (drv_pos == data_in && drv_neg == ~data_in));

    p_read_drive_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |-> (drv_pos == '1 && drv_neg == '1 && !discharge));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en == wr_en) |-> (drv_pos == '0 && drv_neg == '0 && discharge
                              && !precharge && !evaluate));

    always @(posedge clk) begin
        if (rst) begin
            p_reset_levels_r6: assert (!precharge && !evaluate && discharge
                                       && drv_pos == '0 && drv_neg == '0);
        end
    end

    p_phase_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(precharge && evaluate));

    p_eval_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(evaluate) |-> $past(!precharge && !evaluate));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        reprog_err |=> !reprog_err);

    p_blank_zero_r10: assert property (@(posedge clk) disable iff (rst)
        blank |-> (data_oe && data_out == '0));

    p_compl_out_r11: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (data_out_n == ~data_out));

    p_quiet_pins_r11: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == '0 && data_out_n == '0));
endmodule

bind otp_diff_rom otp_diff_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .data_in    (data_in),
    .data_out   (data_out),
    .data_out_n (data_out_n),
    .data_oe    (data_oe),
    .bank_sel_n (bank_sel_n),
    .drv_pos    (drv_pos),
    .drv_neg    (drv_neg),
    .precharge  (precharge),
    .evaluate   (evaluate),
    .discharge  (discharge),
    .reprog_err (reprog_err),
    .blank      (blank)
);

// File: tb/test_otp_diff_rom.sv
module test_otp_diff_rom;
    localparam int PRE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  data_in = '0;
    wire  [7:0]  data_out, data_out_n, drv_pos, drv_neg;
    wire  [15:0] bank_sel_n;
    wire         data_oe, precharge, evaluate, discharge, reprog_err, blank;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    otp_diff_rom i_otp_diff_rom (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_out_n(data_out_n),
        .data_oe(data_oe), .bank_sel_n(bank_sel_n), .drv_pos(drv_pos),
        .drv_neg(drv_neg), .precharge(precharge), .evaluate(evaluate),
        .discharge(discharge), .reprog_err(reprog_err), .blank(blank)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        if (a == 2) return 8'h00;
        if (a == 5) return 8'hFF;
        return 8'((a * 53 + 17) & 255);
    endfunction

    task automatic do_write(input int a, input logic [7:0] d, input logic exp_err);
        @(negedge clk);
        addr = 4'(a); data_in = d; wr_en = 1'b1;
        #1;
        check("R3 drv_pos", {24'd0, drv_pos}, {24'd0, d});
        check("R3 drv_neg", {24'd0, drv_neg}, {24'd0, ~d});
        check("R11 oe in write", {31'd0, data_oe}, 32'd0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R9 err pulse", {31'd0, reprog_err}, {31'd0, exp_err});
        @(negedge clk);
        #1;
        check("R9 err one cycle", {31'd0, reprog_err}, 32'd0);
    endtask

    task automatic do_read(input int a, input logic [7:0] exp, input logic exp_blank);
        @(negedge clk);
        addr = 4'(a); rd_en = 1'b1;
        for (int j = 0; j <= PRE + 2; j++) begin
            #1;
            check("R7 precharge", {31'd0, precharge}, {31'd0, j < PRE});
            check("R7 evaluate", {31'd0, evaluate}, {31'd0, j == PRE + 1});
            check("R11 oe timing", {31'd0, data_oe}, {31'd0, j >= PRE + 2});
            if (j == 0) begin
                check("R4 drives", {16'd0, drv_pos, drv_neg}, 32'h0000FFFF);
                check("R4 discharge", {31'd0, discharge}, 32'd0);
            end
            if (j < PRE + 2) begin
                check("R11 quiet pins", {24'd0, data_out}, 32'd0);
                @(negedge clk);
            end
        end
        check("R1 R8 read data", {24'd0, data_out}, {24'd0, exp});
        check("R11 complement", {24'd0, data_out_n}, {24'd0, ~exp});
        check("R10 blank", {31'd0, blank}, {31'd0, exp_blank});
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        check("R11 oe held one cycle", {31'd0, data_oe}, 32'd1);
        @(negedge clk);
        #1;
        check("R11 oe drop", {31'd0, data_oe}, 32'd0);
        check("R11 pins zero", {16'd0, data_out, data_out_n}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R6: reset levels, even with a read strobe present
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        #1;
        check("R6 precharge", {31'd0, precharge}, 32'd0);
        check("R6 evaluate", {31'd0, evaluate}, 32'd0);
        check("R6 discharge", {31'd0, discharge}, 32'd1);
        check("R6 drives", {16'd0, drv_pos, drv_neg}, 32'd0);
        check("R11 oe reset", {31'd0, data_oe}, 32'd0);
        @(negedge clk);
        rst = 1'b0; rd_en = 1'b0;

        // R2: bank select sweep
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a);
            #1;
            check("R2 bank select", {16'd0, bank_sel_n}, {16'd0, ~(16'd1 << a)});
        end

        // R5: both strobes high acts as idle and burns nothing
        @(negedge clk);
        addr = 4'd13; data_in = 8'hA5; wr_en = 1'b1; rd_en = 1'b1;
        #1;
        check("R5 drives", {16'd0, drv_pos, drv_neg}, 32'd0);
        check("R5 discharge", {31'd0, discharge}, 32'd1);
        check("R5 no precharge", {31'd0, precharge}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1;
        check("R5 no error", {31'd0, reprog_err}, 32'd0);

        // R1: program words 0..11, leave 12..15 blank
        for (int a = 0; a < 12; a++) do_write(a, pat(a), 1'b0);

        // R1 R8 R10: read every address
        for (int a = 0; a < 16; a++) do_read(a, (a < 12) ? pat(a) : 8'h00, a >= 12);

        // R9: reprogram attempts leave the word unchanged
        do_write(3, ~pat(3), 1'b1);
        do_write(2, 8'hFF, 1'b1);
        do_write(5, 8'h00, 1'b1);
        do_read(3, pat(3), 1'b0);
        do_read(2, 8'h00, 1'b0);
        do_read(5, 8'hFF, 1'b0);

        // R6: reset mid-read abandons the sequence, next read restarts
        @(negedge clk);
        addr = 4'd7; rd_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R6 mid-read precharge", {31'd0, precharge}, 32'd0);
        check("R6 mid-read discharge", {31'd0, discharge}, 32'd1);
        @(negedge clk);
        rst = 1'b0; rd_en = 1'b0;
        do_read(7, pat(7), 1'b0);
        do_read(13, 8'h00, 1'b1);

        finish_run();
    end
endmodule